// File: doc/BRIEF.md
# Scan-Testable Binary Up-Counter

This block is a synchronous binary up-counter in which every state bit is a scannable flip-flop. Each bit cell holds a two-way selector in front of its flip-flop. In functional mode the selector takes the counter's next value. In shift mode it takes the neighbouring bit, so the whole register becomes one serial chain.

A tester can use shift mode to place the counter in any state and run one functional clock. It then shifts the result out for comparison. This makes far carries, such as the carry into the top bit, reachable in a few dozen cycles instead of billions. The chain is fed at the least significant bit and read at the most significant bit.

Top module: `scan_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, `count` becomes zero after that edge. This holds whatever the levels of `test_mode`, `count_en` and `scan_in`.
- R2: With `test_mode` low and `count_en` high, `count` increases by one per clock. It wraps from all ones to zero.
- R3: With `test_mode` low and `count_en` low, `count` holds its value.
- R4: With `test_mode` high, each clock moves every bit one place toward the most significant end. Bit 0 takes `scan_in`, and the old top bit leaves the register.
- R5: `scan_out` always equals the most significant bit of `count`. It is therefore the next bit to leave the chain.
- R6: While `test_mode` is high, `count_en` has no effect. The register shifts exactly as in R4 for either level.
- R7: Shift in a zero followed by WIDTH-1 ones, count once, then shift WIDTH more times. The carry check takes 2*WIDTH+1 cycles (65 at WIDTH=32). It shows the value 0111…1 after loading and 1000…0 after the count. The shift-out presents a one followed by WIDTH-1 zeros on `scan_out`.
- R8: While `test_mode` is low, `scan_in` has no effect on `count`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| test_mode | input | 1 | High selects the serial shift path in every bit cell |
| count_en | input | 1 | Increment enable in functional mode |
| scan_in | input | 1 | Serial input into bit 0 |
| count | output | WIDTH | Present counter state |
| scan_out | output | 1 | Serial output from the top bit |

## Verification
The bench builds the counter at its default width of 32. At that width no top-bit carry or wrap could ever be reached by counting alone. Serial loading makes the carry into bit 31 and the all-ones wrap reachable within about seventy cycles each. A vector table covers the interleaving of increments, holds and shifts with the ignored inputs toggled. Directed runs then cover reset in shift mode, the full carry check and the wrap.

// File: rtl/scan_ctr_pkg.sv
package scan_ctr_pkg;

    typedef enum logic {
        PATH_FUNC  = 1'b0,
        PATH_SHIFT = 1'b1
    } cell_path_e;

    function automatic cell_path_e path_of(input logic shift_sel);
        return shift_sel ? PATH_SHIFT : PATH_FUNC;
    endfunction

endpackage

// File: rtl/scan_bit_cell.sv
module scan_bit_cell
    import scan_ctr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cell_path_e path,
    input  logic       d_func,
    input  logic       d_chain,
    output logic       q
);

    logic d_sel;

    always_comb begin
        unique case (path)
            PATH_SHIFT: d_sel = d_chain;
            default:    d_sel = d_func;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= d_sel;
    end

endmodule

// File: rtl/ripple_incr.sv
module ripple_incr #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             inc,
    output logic [WIDTH-1:0] nxt
);

    logic [WIDTH:0] carry;

    assign carry[0] = inc;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign nxt[i]     = cur[i] ^ carry[i];
        assign carry[i+1] = cur[i] & carry[i];
    end

endmodule

// File: rtl/scan_counter.sv
module scan_counter
    import scan_ctr_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             test_mode,
    input  logic             count_en,
    input  logic             scan_in,
    output logic [WIDTH-1:0] count,
    output logic             scan_out
);

    localparam int TOP = WIDTH - 1;

    cell_path_e       path;
    logic [WIDTH-1:0] func_next;
    logic [WIDTH-1:0] chain_in;
    logic [WIDTH-1:0] state_q;

    assign path = path_of(test_mode);

    ripple_incr #(.WIDTH(WIDTH)) u_incr (
        .cur (state_q),
        .inc (count_en),
        .nxt (func_next)
    );

    assign chain_in[0] = scan_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        if (i > 0) begin : g_link
            assign chain_in[i] = state_q[i-1];
        end
        scan_bit_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .path    (path),
            .d_func  (func_next[i]),
            .d_chain (chain_in[i]),
            .q       (state_q[i])
        );
    end

    assign count    = state_q;
    assign scan_out = state_q[TOP];

    // R1: synchronous clear regardless of mode
    a_r1_clear: assert property (@(posedge clk)
        rst |=> (count == '0));

    // R2: functional increment with wrap
    a_r2_increment: assert property (@(posedge clk) disable iff (rst)
        (!test_mode && count_en) |=> (count == $past(count) + 1'b1));

    // R3 and R8: functional hold ignores scan_in
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!test_mode && !count_en) |=> $stable(count));

    // R4 and R6: shift path independent of count_en
    a_r4_shift: assert property (@(posedge clk) disable iff (rst)
        test_mode |=> (count == {$past(count[TOP-1:0]), $past(scan_in)}));

endmodule

// File: tb/sim_scan_counter.sv
module sim_scan_counter;

    localparam int W     = 32;
    localparam int HALF  = 10;
    localparam int NVEC  = 10;

    typedef struct packed {
        logic         tm;
        logic         en;
        logic         si;
        logic [W-1:0] exp;
    } vec_t;

    // walked from a cleared counter; each exp is the state after the clock
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 1'b0, 32'h0000_0001},  // R2
        '{1'b0, 1'b1, 1'b1, 32'h0000_0002},  // R8 scan_in ignored
        '{1'b0, 1'b0, 1'b1, 32'h0000_0002},  // R3 hold
        '{1'b0, 1'b1, 1'b0, 32'h0000_0003},  // R2
        '{1'b1, 1'b0, 1'b1, 32'h0000_0007},  // R4 shift in one
        '{1'b1, 1'b1, 1'b0, 32'h0000_000E},  // R6 enable ignored
        '{1'b1, 1'b0, 1'b0, 32'h0000_001C},  // R4
        '{1'b0, 1'b1, 1'b1, 32'h0000_001D},  // R2/R8
        '{1'b0, 1'b0, 1'b0, 32'h0000_001D},  // R3
        '{1'b1, 1'b1, 1'b1, 32'h0000_003B}   // R6
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         test_mode = 1'b0;
    logic         count_en = 1'b0;
    logic         scan_in = 1'b0;
    logic [W-1:0] count;
    logic         scan_out;

    int checks = 0;
    int errors = 0;

    always #(HALF) clk = ~clk;

    scan_counter #(.WIDTH(W)) u0 (
        .clk       (clk),
        .rst       (rst),
        .test_mode (test_mode),
        .count_en  (count_en),
        .scan_in   (scan_in),
        .count     (count),
        .scan_out  (scan_out)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive on the falling edge, clock once, sample a quarter period later
    task automatic step(input logic tm, input logic en, input logic si, input logic r);
        @(negedge clk);
        test_mode = tm;
        count_en  = en;
        scan_in   = si;
        rst       = r;
        @(posedge clk);
        #(HALF/2);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(2 * HALF * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [W-1:0] model;
        logic [W-1:0] outbits;

        // R1 reset state
        step(1'b0, 1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1, 1'b1);
        check("R1 reset count", count, '0);
        check("R5 scan_out after reset", {31'd0, scan_out}, 32'd0);

        step(1'b0, 1'b0, 1'b0, 1'b0);
        check("R3 idle after reset", count, '0);

        for (int i = 0; i < NVEC; i++) begin
            step(VECS[i].tm, VECS[i].en, VECS[i].si, 1'b0);
            check("R2/R3/R4/R6/R8 vector", count, VECS[i].exp);
            check("R5 scan_out tracks top bit", {31'd0, scan_out}, {31'd0, VECS[i].exp[W-1]});
        end

        // R1 reset while in shift mode with scan_in high
        step(1'b1, 1'b1, 1'b1, 1'b1);
        check("R1 reset in test mode", count, '0);

        // R7 carry check: zero first, then W-1 ones
        step(1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 1; i < W; i++) step(1'b1, 1'b0, 1'b1, 1'b0);
        check("R7 loaded pattern", count, 32'h7FFF_FFFF);
        check("R5 scan_out zero when top bit clear", {31'd0, scan_out}, 32'd0);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        check("R7 carry into top bit", count, 32'h8000_0000);
        outbits = '0;
        for (int i = 0; i < W; i++) begin
            outbits = {outbits[W-2:0], scan_out};
            step(1'b1, 1'b0, 1'b0, 1'b0);
        end
        check("R7 shifted-out stream", outbits, 32'h8000_0000);
        check("R4 register empty after full shift", count, '0);

        // R2 wrap: load all ones, then count
        for (int i = 0; i < W; i++) step(1'b1, 1'b0, 1'b1, 1'b0);
        check("R4 all ones loaded", count, 32'hFFFF_FFFF);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        check("R2 wrap to zero", count, '0);

        // R8 and R3: toggling scan_in while holding
        model = '0;
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b0, i[0], 1'b0);
            check("R8 scan_in ignored in hold", count, model);
        end

        finish_run();
    end

endmodule